// File: doc/BRIEF.md
# Receive Frame Acceptance Filter

This block makes the keep-or-drop decision for each frame arriving at an Ethernet receiver. When the frame is over, the receive path presents three things:

- the destination address;
- the three error flags collected during reception: bad CRC, misalignment and collision fragment;
- the final byte count.

The receive path raises a single-cycle end-of-frame strobe while these are valid. The filter sorts the destination into one of four classes: broadcast, multicast, unicast to this station, or unicast to another station. It checks that class against the software-set enables. In the same cycle it qualifies the error and length status. It registers one verdict, which appears on the cycle after the strobe.

The filter has six configuration inputs: error acceptance, runt acceptance, broadcast, multicast, own-address match, and accept-all-unicast. Multicast frames also need the hash-hit input, which comes from a hash table outside the block. The storage stage uses the verdict to commit or discard the buffered frame. Computing the CRC, the hash and storing the frame are done elsewhere.

Top module: `rx_accept_filter`

## Requirements
- R1: `verdict_valid` is high for exactly one cycle, in the cycle after each cycle where `frame_end` is sampled high. `verdict_keep` is never high while `verdict_valid` is low.
- R2: While `rst` is high, and in the first cycle after it, `verdict_valid` and `verdict_keep` are low.
- R3: A frame whose `frame_len` is below 8 is rejected under every configuration.
- R4: A frame whose length is from 8 to 63 is kept only when `cfg_accept_runt` is 1. A length of 64 or more is never rejected for its length.
- R5: If any of `crc_err`, `align_err` or `coll_frag` is 1, the frame is rejected unless `cfg_accept_err` is 1.
- R6: A destination of all ones is broadcast. Such a frame is kept only when `cfg_accept_bcast` is 1.
- R7: A destination that is not all ones, with its group bit (`dest_addr[40]`, the least significant bit of the first byte `dest_addr[47:40]`) set, is multicast. It is kept only when `cfg_accept_mcast` and `hash_hit` are both 1.
- R8: A unicast destination equal to `station_addr` is kept when `cfg_accept_match` is 1 or `cfg_accept_all` is 1.
- R9: A unicast destination different from `station_addr` is kept only when `cfg_accept_all` is 1. `cfg_accept_all` does not admit broadcast or multicast frames.
- R10: Inputs are used only in the cycle where `frame_end` is high. Changing them in any other cycle produces no verdict and has no effect on the next verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_accept_err | input | 1 | Keep frames that carry an error flag |
| cfg_accept_runt | input | 1 | Keep frames of 8 to 63 bytes |
| cfg_accept_bcast | input | 1 | Keep broadcast frames |
| cfg_accept_mcast | input | 1 | Keep multicast frames that hit the hash |
| cfg_accept_match | input | 1 | Keep unicast frames addressed to this station |
| cfg_accept_all | input | 1 | Keep every unicast frame |
| dest_addr | input | 48 | Destination address, first byte in [47:40] |
| station_addr | input | 48 | This station's own address |
| hash_hit | input | 1 | Multicast hash table hit for this frame |
| crc_err | input | 1 | Frame check sequence mismatch |
| align_err | input | 1 | Frame ended on a non-byte boundary |
| coll_frag | input | 1 | Frame is a collision fragment |
| frame_end | input | 1 | One-cycle strobe: frame complete, inputs valid |
| frame_len | input | 16 | Final frame length in bytes |
| verdict_valid | output | 1 | Decision strobe, one cycle after `frame_end` |
| verdict_keep | output | 1 | 1 = keep the frame, 0 = drop it |

## Verification
The assertions assume `frame_end` is a clean synchronous pulse. They also assume the address, flag, length and configuration inputs are stable in the strobe cycle, because every verdict property reads them there. The bench drives all inputs on the falling edge and holds them through the sampling rising edge. It keeps `frame_end` low between frames, except in one back-to-back case where two strobes follow each other and each has its own input set. In the idle scenario the bench deliberately wiggles the inputs with `frame_end` low, which the assertions allow because they only look at strobe cycles.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    typedef enum logic [1:0] {
        DST_UCAST_OTHER = 2'd0,
        DST_UCAST_OWN   = 2'd1,
        DST_MCAST       = 2'd2,
        DST_BCAST       = 2'd3
    } dst_class_e;

    typedef enum logic [1:0] {
        LEN_TOO_SHORT = 2'd0,
        LEN_RUNT      = 2'd1,
        LEN_FULL      = 2'd2
    } len_class_e;

    typedef struct packed {
        logic accept_err;
        logic accept_runt;
        logic accept_bcast;
        logic accept_mcast;
        logic accept_match;
        logic accept_all;
    } filt_cfg_t;

    function automatic logic class_allowed(dst_class_e cls, filt_cfg_t cfg, logic hash_hit);
        logic ok;
        case (cls)
            DST_BCAST:       ok = cfg.accept_bcast;
            DST_MCAST:       ok = cfg.accept_mcast & hash_hit;
            DST_UCAST_OWN:   ok = cfg.accept_match | cfg.accept_all;
            default:         ok = cfg.accept_all;
        endcase
        return ok;
    endfunction

    function automatic logic length_allowed(len_class_e lc, filt_cfg_t cfg);
        logic ok;
        case (lc)
            LEN_FULL: ok = 1'b1;
            LEN_RUNT: ok = cfg.accept_runt;
            default:  ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/rxf_addr_classify.sv
module rxf_addr_classify
    import rxf_pkg::*;
#(
    parameter int ADDR_W = 48
) (
    input  logic [ADDR_W-1:0] dest_addr,
    input  logic [ADDR_W-1:0] station_addr,
    output dst_class_e        dst_class
);
    localparam int GROUP_BIT = ADDR_W - 8;

    logic is_bcast;
    logic is_group;
    logic is_own;

    assign is_bcast = &dest_addr;
    assign is_group = dest_addr[GROUP_BIT];
    assign is_own   = (dest_addr == station_addr);

    always_comb begin
        if (is_bcast)
            dst_class = DST_BCAST;
        else if (is_group)
            dst_class = DST_MCAST;
        else if (is_own)
            dst_class = DST_UCAST_OWN;
        else
            dst_class = DST_UCAST_OTHER;
    end
endmodule

// File: rtl/rxf_len_classify.sv
module rxf_len_classify
    import rxf_pkg::*;
#(
    parameter int LEN_W      = 16,
    parameter int RUNT_FLOOR = 8,
    parameter int MIN_FRAME  = 64
) (
    input  logic [LEN_W-1:0] frame_len,
    output len_class_e       len_class
);
    localparam logic [LEN_W-1:0] FLOOR_V = LEN_W'(RUNT_FLOOR);
    localparam logic [LEN_W-1:0] MIN_V   = LEN_W'(MIN_FRAME);

    always_comb begin
        if (frame_len < FLOOR_V)
            len_class = LEN_TOO_SHORT;
        else if (frame_len < MIN_V)
            len_class = LEN_RUNT;
        else
            len_class = LEN_FULL;
    end
endmodule

// File: rtl/rx_accept_filter.sv
module rx_accept_filter
    import rxf_pkg::*;
#(
    parameter int ADDR_W     = 48,
    parameter int LEN_W      = 16,
    parameter int RUNT_FLOOR = 8,
    parameter int MIN_FRAME  = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_accept_err,
    input  logic              cfg_accept_runt,
    input  logic              cfg_accept_bcast,
    input  logic              cfg_accept_mcast,
    input  logic              cfg_accept_match,
    input  logic              cfg_accept_all,
    input  logic [ADDR_W-1:0] dest_addr,
    input  logic [ADDR_W-1:0] station_addr,
    input  logic              hash_hit,
    input  logic              crc_err,
    input  logic              align_err,
    input  logic              coll_frag,
    input  logic              frame_end,
    input  logic [LEN_W-1:0]  frame_len,
    output logic              verdict_valid,
    output logic              verdict_keep
);
    filt_cfg_t  cfg;
    dst_class_e dst_class;
    len_class_e len_class;
    logic       any_err;
    logic       err_ok;
    logic       pass;

    assign cfg = '{accept_err:   cfg_accept_err,
                   accept_runt:  cfg_accept_runt,
                   accept_bcast: cfg_accept_bcast,
                   accept_mcast: cfg_accept_mcast,
                   accept_match: cfg_accept_match,
                   accept_all:   cfg_accept_all};

    rxf_addr_classify #(.ADDR_W(ADDR_W)) u_addr (
        .dest_addr    (dest_addr),
        .station_addr (station_addr),
        .dst_class    (dst_class)
    );

    rxf_len_classify #(
        .LEN_W      (LEN_W),
        .RUNT_FLOOR (RUNT_FLOOR),
        .MIN_FRAME  (MIN_FRAME)
    ) u_len (
        .frame_len (frame_len),
        .len_class (len_class)
    );

    assign any_err = crc_err | align_err | coll_frag;
    assign err_ok  = ~any_err | cfg.accept_err;
    assign pass    = err_ok
                   & class_allowed(dst_class, cfg, hash_hit)
                   & length_allowed(len_class, cfg);

    always_ff @(posedge clk) begin
        if (rst) begin
            verdict_valid <= 1'b0;
            verdict_keep  <= 1'b0;
        end else begin
            verdict_valid <= frame_end;
            verdict_keep  <= frame_end & pass;
        end
    end
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
    parameter int ADDR_W     = 48,
    parameter int LEN_W      = 16,
    parameter int RUNT_FLOOR = 8,
    parameter int MIN_FRAME  = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              frame_end,
    input logic [LEN_W-1:0]  frame_len,
    input logic              crc_err,
    input logic              align_err,
    input logic              coll_frag,
    input logic              cfg_accept_err,
    input logic              cfg_accept_runt,
    input logic              cfg_accept_bcast,
    input logic [ADDR_W-1:0] dest_addr,
    input logic              verdict_valid,
    input logic              verdict_keep
);
    localparam logic [LEN_W-1:0] FLOOR_V = LEN_W'(RUNT_FLOOR);
    localparam logic [LEN_W-1:0] MIN_V   = LEN_W'(MIN_FRAME);

    assert_valid_after_end_R1: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> verdict_valid);

    assert_valid_needs_end_R10: assert property (@(posedge clk) disable iff (rst)
        verdict_valid |-> $past(frame_end));

    assert_keep_needs_valid_R1: assert property (@(posedge clk) disable iff (rst)
        !verdict_valid |-> !verdict_keep);

    assert_short_dropped_R3: assert property (@(posedge clk) disable iff (rst)
        (frame_end && frame_len < FLOOR_V) |=> !verdict_keep);

    assert_runt_gated_R4: assert property (@(posedge clk) disable iff (rst)
        (frame_end && frame_len < MIN_V && !cfg_accept_runt) |=> !verdict_keep);

    assert_err_gated_R5: assert property (@(posedge clk) disable iff (rst)
        (frame_end && (crc_err || align_err || coll_frag) && !cfg_accept_err) |=> !verdict_keep);

    assert_bcast_gated_R6: assert property (@(posedge clk) disable iff (rst)
        (frame_end && (&dest_addr) && !cfg_accept_bcast) |=> !verdict_keep);
endmodule

bind rx_accept_filter rxf_checker #(
    .ADDR_W     (ADDR_W),
    .LEN_W      (LEN_W),
    .RUNT_FLOOR (RUNT_FLOOR),
    .MIN_FRAME  (MIN_FRAME)
) u_rxf_checker (
    .clk              (clk),
    .rst              (rst),
    .frame_end        (frame_end),
    .frame_len        (frame_len),
    .crc_err          (crc_err),
    .align_err        (align_err),
    .coll_frag        (coll_frag),
    .cfg_accept_err   (cfg_accept_err),
    .cfg_accept_runt  (cfg_accept_runt),
    .cfg_accept_bcast (cfg_accept_bcast),
    .dest_addr        (dest_addr),
    .verdict_valid    (verdict_valid),
    .verdict_keep     (verdict_keep)
);

// File: tb/test_rx_accept_filter.sv
module test_rx_accept_filter;
    localparam logic [47:0] STATION = 48'h02_11_22_33_44_55;
    localparam logic [47:0] OTHER   = 48'h02_11_22_33_44_66;
    localparam logic [47:0] MCAST   = 48'h01_00_5E_00_00_01;
    localparam logic [47:0] BCAST   = 48'hFFFF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        c_err = 0, c_runt = 0, c_bc = 0, c_mc = 0, c_match = 0, c_all = 0;
    logic [47:0] dest_addr = '0;
    logic        hash_hit = 0, crc_err = 0, align_err = 0, coll_frag = 0;
    logic        frame_end = 0;
    logic [15:0] frame_len = 16'd0;
    logic        verdict_valid, verdict_keep;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    rx_accept_filter i_rx_accept_filter (
        .clk(clk), .rst(rst),
        .cfg_accept_err(c_err), .cfg_accept_runt(c_runt),
        .cfg_accept_bcast(c_bc), .cfg_accept_mcast(c_mc),
        .cfg_accept_match(c_match), .cfg_accept_all(c_all),
        .dest_addr(dest_addr), .station_addr(STATION),
        .hash_hit(hash_hit), .crc_err(crc_err), .align_err(align_err),
        .coll_frag(coll_frag), .frame_end(frame_end), .frame_len(frame_len),
        .verdict_valid(verdict_valid), .verdict_keep(verdict_keep)
    );

    task automatic check(input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%b expected=%b", what, act, exp);
        end
    endtask

    task automatic set_cfg(input logic e, input logic r, input logic b,
                           input logic m, input logic p, input logic a);
        c_err = e; c_runt = r; c_bc = b; c_mc = m; c_match = p; c_all = a;
    endtask

    // One frame: strobe for one cycle, verdict checked next cycle, then pulse end.
    task automatic frame(input logic [47:0] d, input logic [15:0] len,
                         input logic [2:0] errs, input logic hh,
                         input logic exp_keep, input string what);
        @(negedge clk);
        dest_addr = d; frame_len = len; hash_hit = hh;
        {crc_err, align_err, coll_frag} = errs;
        frame_end = 1'b1;
        @(negedge clk);
        frame_end = 1'b0;
        check(verdict_valid, 1'b1, {what, " valid R1"});
        check(verdict_keep, exp_keep, what);
        @(negedge clk);
        check(verdict_valid, 1'b0, {what, " pulse end R1"});
        check(verdict_keep, 1'b0, {what, " keep low R1"});
    endtask

    task automatic t_reset;
        repeat (2) @(negedge clk);
        check(verdict_valid, 1'b0, "R2 valid in reset");
        check(verdict_keep, 1'b0, "R2 keep in reset");
        frame_end = 1'b1;
        @(negedge clk);
        check(verdict_valid, 1'b0, "R2 strobe ignored in reset");
        frame_end = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check(verdict_valid, 1'b0, "R2 first cycle after reset");
    endtask

    task automatic t_broadcast;
        set_cfg(0, 0, 0, 1, 1, 1);
        frame(BCAST, 16'd100, 3'b000, 1'b1, 1'b0, "R6 bcast disabled");
        set_cfg(0, 0, 1, 0, 0, 0);
        frame(BCAST, 16'd100, 3'b000, 1'b0, 1'b1, "R6 bcast enabled");
    endtask

    task automatic t_multicast;
        set_cfg(0, 0, 0, 1, 0, 0);
        frame(MCAST, 16'd80, 3'b000, 1'b1, 1'b1, "R7 mcast hash hit");
        frame(MCAST, 16'd80, 3'b000, 1'b0, 1'b0, "R7 mcast hash miss");
        set_cfg(0, 0, 1, 0, 1, 1);
        frame(MCAST, 16'd80, 3'b000, 1'b1, 1'b0, "R7 R9 mcast disabled, accept-all set");
    endtask

    task automatic t_unicast;
        set_cfg(0, 0, 0, 0, 1, 0);
        frame(STATION, 16'd64, 3'b000, 1'b0, 1'b1, "R8 own with match");
        frame(OTHER, 16'd64, 3'b000, 1'b0, 1'b0, "R9 other without all");
        set_cfg(0, 0, 1, 1, 0, 0);
        frame(STATION, 16'd64, 3'b000, 1'b1, 1'b0, "R8 own, match off");
        set_cfg(0, 0, 0, 0, 0, 1);
        frame(STATION, 16'd64, 3'b000, 1'b0, 1'b1, "R8 own via accept-all");
        frame(OTHER, 16'd1518, 3'b000, 1'b0, 1'b1, "R9 other via accept-all");
    endtask

    task automatic t_errors;
        set_cfg(0, 0, 0, 0, 1, 0);
        frame(STATION, 16'd100, 3'b100, 1'b0, 1'b0, "R5 crc rejected");
        frame(STATION, 16'd100, 3'b010, 1'b0, 1'b0, "R5 align rejected");
        frame(STATION, 16'd100, 3'b001, 1'b0, 1'b0, "R5 collision rejected");
        set_cfg(1, 0, 0, 0, 1, 0);
        frame(STATION, 16'd100, 3'b111, 1'b0, 1'b1, "R5 errors accepted");
        frame(OTHER, 16'd100, 3'b100, 1'b0, 1'b0, "R5 error ok but class off");
    endtask

    task automatic t_length;
        set_cfg(1, 1, 1, 1, 1, 1);
        frame(STATION, 16'd7, 3'b000, 1'b0, 1'b0, "R3 len 7 all enabled");
        frame(STATION, 16'd0, 3'b000, 1'b0, 1'b0, "R3 len 0");
        frame(STATION, 16'd8, 3'b000, 1'b0, 1'b1, "R4 len 8 runt on");
        frame(STATION, 16'd63, 3'b000, 1'b0, 1'b1, "R4 len 63 runt on");
        set_cfg(0, 0, 0, 0, 1, 0);
        frame(STATION, 16'd8, 3'b000, 1'b0, 1'b0, "R4 len 8 runt off");
        frame(STATION, 16'd63, 3'b000, 1'b0, 1'b0, "R4 len 63 runt off");
        frame(STATION, 16'd64, 3'b000, 1'b0, 1'b1, "R4 len 64 runt off");
    endtask

    task automatic t_idle_and_sampling;
        set_cfg(0, 0, 0, 0, 1, 0);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            dest_addr = (i % 2 == 0) ? STATION : BCAST;
            crc_err = i[0];
            frame_len = 16'(i * 20);
            check(verdict_valid, 1'b0, "R10 no verdict without strobe");
            check(verdict_keep, 1'b0, "R10 keep low without strobe");
        end
        frame(STATION, 16'd200, 3'b000, 1'b0, 1'b1, "R10 strobe-cycle inputs decide");
        // back-to-back strobes, each with its own inputs
        @(negedge clk);
        dest_addr = STATION; frame_len = 16'd90; {crc_err, align_err, coll_frag} = 3'b000;
        frame_end = 1'b1;
        @(negedge clk);
        check(verdict_valid, 1'b1, "R1 back-to-back first valid");
        check(verdict_keep, 1'b1, "R10 back-to-back first keep");
        dest_addr = OTHER;
        @(negedge clk);
        frame_end = 1'b0;
        check(verdict_valid, 1'b1, "R1 back-to-back second valid");
        check(verdict_keep, 1'b0, "R10 back-to-back second keep");
        @(negedge clk);
        check(verdict_valid, 1'b0, "R1 back-to-back ends");
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        t_reset();
        t_broadcast();
        t_multicast();
        t_unicast();
        t_errors();
        t_length();
        t_idle_and_sampling();
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end
endmodule